// File: doc/BRIEF.md
# Maskable Interrupt Status Register Unit

This block holds a small interrupt status word and a 32-bit interrupt enable mask, both reachable through 32-bit register writes and combinational register reads at two fixed offsets. Internal event strobes set status bits: a completion event sets bit 0 and a message event sets bit 1. Software acknowledges an event by writing ones to the status offset. Each one written clears the matching status bit. Writing the mask offset replaces the whole enable mask.

An interrupt is requested whenever the mask and the status share a set bit. A mode input selects how the request is signalled. In line mode a level output follows the request. In message mode the block emits a one-cycle pulse, and only after an update (a status set, a status write or a mask write) whose result still requests an interrupt. Every write to the status offset also gives a one-cycle acknowledge pulse. A completion drain engine uses that pulse to retry emptying its queue.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status reads 0 and the mask reads 0, and `irq_line`, `irq_pulse` and `ack_pulse` are all low.
- R2: A high `cmpl_evt` sets status bit 0, and a high `msg_evt` sets status bit 1. Each bit reads as set from the cycle after the strobe and stays set until it is cleared.
- R3: A write to the status offset (0x10) clears every status bit whose position holds a one in the write data, and leaves the other bits unchanged. If a set event for a bit arrives in the same cycle as a clear of that bit, the bit remains set.
- R4: A write to the mask offset (0x14) replaces all 32 mask bits with the write data.
- R5: A read returns the status (zero-extended) at 0x10, the mask at 0x14, and 0 at any other offset. A write to any other offset changes neither the status nor the mask.
- R6: With `msi_mode` = 0, `irq_line` is high exactly when (mask AND status) is non-zero, one cycle after the register update that caused it. `irq_pulse` stays low.
- R7: With `msi_mode` = 1, `irq_line` stays low. `irq_pulse` is high for one cycle, in the cycle after a status set, status write or mask write whose resulting (mask AND status) is non-zero. No pulse follows an update whose result is zero.
- R8: When a set event arrives in the same cycle as the only other reason for a notification, the message-mode pulse decision uses the status that already includes the new bit.
- R9: Every write to the status offset, including a write of zero, produces a one-cycle `ack_pulse` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset for both reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cmpl_evt | input | 1 | Completion event strobe, sets status bit 0 |
| msg_evt | input | 1 | Message event strobe, sets status bit 1 |
| msi_mode | input | 1 | 1 selects pulse signalling, 0 selects level line |
| irq_line | output | 1 | Level interrupt request (line mode) |
| irq_pulse | output | 1 | One-cycle notification (message mode) |
| ack_pulse | output | 1 | One-cycle pulse after each status write |

## Verification
The hardest case to reach from the ports is a set event and a status write in the same clock edge. Here two things must hold together: the set-wins rule for a bit that is being cleared, and a message-mode pulse decision that must see the fresh status rather than the old one. The stimulus places the event strobe and the write strobe in the same cycle. First it uses a mask that enables only the bit being set, so a stale evaluation would miss the pulse. Then it repeats with the same bit both set and cleared, so the readback shows which side won.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Holds the types shared by the interrupt status unit: the per-cycle
// write-select decode and the read-source selector.
package irq_pkg;

    // Which register a bus write targets this cycle (at most one is set).
    typedef struct packed {
        logic stat_wr;
        logic mask_wr;
    } wr_sel_t;

    // Source that drives the read data bus.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_STAT = 2'd1,
        RD_MASK = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
// Module irq_reg_decode
// Decodes the register offset into a write select and a read source.
// Assumes the offsets differ; any other offset decodes to "no register".
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h14
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output wr_sel_t           wsel,
    output rd_sel_e           rsel
);

    logic hit_stat;
    logic hit_mask;

    // Compare the offset against the two register locations.
    always_comb begin
        hit_stat = (bus_addr == STAT_OFS);
        hit_mask = (bus_addr == MASK_OFS);
    end

    // Qualify writes with the strobe; unknown offsets select nothing.
    always_comb begin
        wsel.stat_wr = bus_wr && hit_stat;
        wsel.mask_wr = bus_wr && hit_mask;
    end

    // Pick the read source; unknown offsets read as zero.
    always_comb begin
        if (hit_stat)      rsel = RD_STAT;
        else if (hit_mask) rsel = RD_MASK;
        else               rsel = RD_NONE;
    end

endmodule

// File: rtl/irq_status_core.sv
// Module irq_status_core
// Holds the status bits (set by events, cleared by writing ones) and the
// full-width enable mask. It exposes the next-state values, so that the
// notifier can judge a request against the state the edge will produce.
// Assumes that a set event outranks a clear of the same bit in one cycle.
module irq_status_core
    import irq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_EVT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  wr_sel_t           wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_EVT-1:0] status_q,
    output logic [DATA_W-1:0]  mask_q,
    output logic [NUM_EVT-1:0] status_nxt,
    output logic [DATA_W-1:0]  mask_nxt,
    output logic               upd
);

    // One status bit per event source, each with its own set and clear terms.
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        logic clr_bit;

        // Clear request for this bit from a status write.
        always_comb clr_bit = wsel.stat_wr && wdata[i];

        // Next value: a set wins over a clear in the same cycle.
        always_comb status_nxt[i] = evt_set[i] | (status_q[i] & ~clr_bit);

        // Register the bit; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= status_nxt[i];
        end
    end

    // Next mask: replaced whole on a mask write.
    always_comb mask_nxt = wsel.mask_wr ? wdata : mask_q;

    // Register the mask; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

    // Any action that calls for the request to be evaluated again.
    always_comb upd = (|evt_set) | wsel.stat_wr | wsel.mask_wr;

endmodule

// File: rtl/irq_notify.sv
// Module irq_notify
// Turns the masked status into either a level line or a one-cycle pulse,
// and produces the acknowledge pulse for status writes. The pulse decision
// uses next-state values, so it matches the state registered at that edge.
module irq_notify #(
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_mode,
    input  logic [NUM_EVT-1:0] status_q,
    input  logic [NUM_EVT-1:0] mask_lo_q,
    input  logic [NUM_EVT-1:0] status_nxt,
    input  logic [NUM_EVT-1:0] mask_lo_nxt,
    input  logic               upd,
    input  logic               stat_wr,
    output logic               irq_line,
    output logic               irq_pulse,
    output logic               ack_pulse
);

    logic req_now;
    logic req_next;

    // Request level now, and the level after the coming edge.
    always_comb begin
        req_now  = |(status_q & mask_lo_q);
        req_next = |(status_nxt & mask_lo_nxt);
    end

    // Level line follows the request, but only in line mode.
    always_comb irq_line = !msi_mode && req_now;

    // Pulse after an update that leaves a request; nothing on deassertion.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= msi_mode && upd && req_next;
    end

    // Acknowledge pulse after any status write.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_pulse <= 1'b0;
        else        ack_pulse <= stat_wr;
    end

endmodule

// File: rtl/irq_status_unit.sv
// Module irq_status_unit
// Top of the maskable interrupt status unit. It connects the offset decode,
// the status and mask storage and the notifier, and muxes the read data.
// Assumes single-cycle write strobes and event strobes.
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                NUM_EVT  = 2,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmpl_evt,
    input  logic              msg_evt,
    input  logic              msi_mode,
    output logic              irq_line,
    output logic              irq_pulse,
    output logic              ack_pulse
);

    localparam int PAD_W = DATA_W - NUM_EVT;

    wr_sel_t              wsel;
    rd_sel_e              rsel;
    logic [NUM_EVT-1:0]   evt_set;
    logic [NUM_EVT-1:0]   status_q;
    logic [NUM_EVT-1:0]   status_nxt;
    logic [DATA_W-1:0]    mask_q;
    logic [DATA_W-1:0]    mask_nxt;
    logic                 upd;

    // Map the named event strobes onto the status bit positions.
    always_comb begin
        evt_set    = '0;
        evt_set[0] = cmpl_evt;
        evt_set[1] = msg_evt;
    end

    irq_reg_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .wsel     (wsel),
        .rsel     (rsel)
    );

    irq_status_core #(
        .DATA_W  (DATA_W),
        .NUM_EVT (NUM_EVT)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (evt_set),
        .wsel       (wsel),
        .wdata      (bus_wdata),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .status_nxt (status_nxt),
        .mask_nxt   (mask_nxt),
        .upd        (upd)
    );

    irq_notify #(
        .NUM_EVT (NUM_EVT)
    ) u_notify (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_mode    (msi_mode),
        .status_q    (status_q),
        .mask_lo_q   (mask_q[NUM_EVT-1:0]),
        .status_nxt  (status_nxt),
        .mask_lo_nxt (mask_nxt[NUM_EVT-1:0]),
        .upd         (upd),
        .stat_wr     (wsel.stat_wr),
        .irq_line    (irq_line),
        .irq_pulse   (irq_pulse),
        .ack_pulse   (ack_pulse)
    );

    // Read mux: status zero-extended, mask whole, zero elsewhere.
    always_comb begin
        case (rsel)
            RD_STAT: bus_rdata = {{PAD_W{1'b0}}, status_q};
            RD_MASK: bus_rdata = mask_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_unit_chk.sv
// Module irq_status_unit_chk
// Property checker for irq_status_unit, attached through bind. It watches
// the ports and the registered status and mask.
module irq_status_unit_chk #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                NUM_EVT  = 2,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cmpl_evt,
    input logic              msg_evt,
    input logic              msi_mode,
    input logic              irq_line,
    input logic              irq_pulse,
    input logic              ack_pulse,
    input logic [NUM_EVT-1:0] status_q,
    input logic [DATA_W-1:0]  mask_q
);

    // R2: a completion strobe leaves bit 0 set.
    p_cmpl_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_evt |=> status_q[0]);

    // R2: a message strobe leaves bit 1 set.
    p_msg_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_evt |=> status_q[1]);

    // R3: a status write with no event clears every bit written as one.
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_OFS && !cmpl_evt && !msg_evt)
        |=> ((status_q & $past(bus_wdata[NUM_EVT-1:0])) == '0));

    // R4: a mask write replaces the whole mask.
    p_mask_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == MASK_OFS) |=> (mask_q == $past(bus_wdata)));

    // R5: unknown offsets read as zero.
    p_unknown_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STAT_OFS && bus_addr != MASK_OFS) |-> (bus_rdata == '0));

    // R6: in line mode the line matches the masked status.
    p_line_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_mode |-> (irq_line == (|(status_q & mask_q[NUM_EVT-1:0]))));

    // R7: the line stays quiet in message mode.
    p_msi_line_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msi_mode |-> !irq_line);

    // R7: a pulse only follows a cycle spent in message mode.
    p_pulse_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(msi_mode));

    // R8: a pulse always coincides with a live masked request.
    p_pulse_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (|(status_q & mask_q[NUM_EVT-1:0])));

    // R9: every status write is followed by an acknowledge pulse.
    p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_OFS) |=> ack_pulse);

endmodule

bind irq_status_unit irq_status_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_EVT  (NUM_EVT),
    .STAT_OFS (STAT_OFS),
    .MASK_OFS (MASK_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmpl_evt  (cmpl_evt),
    .msg_evt   (msg_evt),
    .msi_mode  (msi_mode),
    .irq_line  (irq_line),
    .irq_pulse (irq_pulse),
    .ack_pulse (ack_pulse),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/irq_status_unit_bench.sv
// Directed bench for irq_status_unit: one task per scenario. Inputs change
// on the falling edge and outputs are sampled on the falling edge.
module irq_status_unit_bench;

    localparam logic [7:0] STAT = 8'h10;
    localparam logic [7:0] MASK = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmpl_evt = 1'b0;
    logic        msg_evt = 1'b0;
    logic        msi_mode = 1'b0;
    logic        irq_line;
    logic        irq_pulse;
    logic        ack_pulse;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmpl_evt(cmpl_evt),
        .msg_evt(msg_evt), .msi_mode(msi_mode), .irq_line(irq_line),
        .irq_pulse(irq_pulse), .ack_pulse(ack_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Read a register combinationally at the current falling edge.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // One clock of activity: optional write and events, then settle on the next falling edge.
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic ce, input logic me);
        bus_wr = wr; bus_addr = a; bus_wdata = d; cmpl_evt = ce; msg_evt = me;
        @(negedge clk);
        bus_wr = 1'b0; cmpl_evt = 1'b0; msg_evt = 1'b0; bus_addr = 8'h00;
        #0.5;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(STAT, d); chk("R1 status", d, 0);
        rd(MASK, d); chk("R1 mask", d, 0);
        chk("R1 outputs", {29'd0, irq_line, irq_pulse, ack_pulse}, 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        step(1'b0, 8'h00, 0, 1'b1, 1'b0);
        rd(STAT, d); chk("R2 completion bit0", d, 32'h1);
        step(1'b0, 8'h00, 0, 1'b0, 1'b1);
        rd(STAT, d); chk("R2 message bit1", d, 32'h3);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        step(1'b1, STAT, 32'hFFFF_FFFE, 1'b0, 1'b0);
        rd(STAT, d); chk("R3 clear bit1 keep bit0", d, 32'h1);
        step(1'b1, STAT, 32'h1, 1'b1, 1'b0);
        rd(STAT, d); chk("R3 set wins over clear", d, 32'h1);
        step(1'b1, STAT, 32'h3, 1'b0, 1'b0);
        rd(STAT, d); chk("R3 clear all", d, 32'h0);
    endtask

    task automatic t_mask_decode();
        logic [31:0] d;
        step(1'b1, MASK, 32'hA5A5_0003, 1'b0, 1'b0);
        rd(MASK, d); chk("R4 mask replace", d, 32'hA5A5_0003);
        step(1'b1, MASK, 32'h0000_0001, 1'b0, 1'b0);
        rd(MASK, d); chk("R4 mask replace again", d, 32'h1);
        step(1'b1, 8'h18, 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd(MASK, d); chk("R5 unknown write mask", d, 32'h1);
        rd(STAT, d); chk("R5 unknown write status", d, 32'h0);
        rd(8'h18, d); chk("R5 unknown read zero", d, 32'h0);
    endtask

    task automatic t_line();
        logic [31:0] d;
        msi_mode = 1'b0;
        step(1'b0, 8'h00, 0, 1'b0, 1'b1);
        chk("R6 masked-off bit no line", {31'd0, irq_line}, 0);
        step(1'b0, 8'h00, 0, 1'b1, 1'b0);
        chk("R6 line high", {31'd0, irq_line}, 1);
        chk("R6 no pulse in line mode", {31'd0, irq_pulse}, 0);
        step(1'b1, MASK, 32'h0, 1'b0, 1'b0);
        chk("R6 line low after mask", {31'd0, irq_line}, 0);
        step(1'b1, STAT, 32'h3, 1'b0, 1'b0);
        rd(STAT, d); chk("R6 cleanup", d, 0);
    endtask

    task automatic t_msi();
        msi_mode = 1'b1;
        step(1'b1, MASK, 32'h3, 1'b0, 1'b0);
        chk("R7 no pulse, empty status", {31'd0, irq_pulse}, 0);
        step(1'b0, 8'h00, 0, 1'b1, 1'b0);
        chk("R7 pulse after event", {31'd0, irq_pulse}, 1);
        chk("R7 line low in msg mode", {31'd0, irq_line}, 0);
        step(1'b0, 8'h00, 0, 1'b0, 1'b0);
        chk("R7 pulse one cycle", {31'd0, irq_pulse}, 0);
        step(1'b1, STAT, 32'h1, 1'b0, 1'b0);
        chk("R7 no pulse on deassert", {31'd0, irq_pulse}, 0);
        chk("R9 ack after clear write", {31'd0, ack_pulse}, 1);
        step(1'b0, 8'h00, 0, 1'b0, 1'b0);
        chk("R9 ack one cycle", {31'd0, ack_pulse}, 0);
        step(1'b1, STAT, 32'h0, 1'b0, 1'b0);
        chk("R9 ack on zero write", {31'd0, ack_pulse}, 1);
    endtask

    task automatic t_coincide();
        logic [31:0] d;
        step(1'b1, MASK, 32'h2, 1'b0, 1'b0);
        step(1'b0, 8'h00, 0, 1'b0, 1'b1);
        chk("R8 pulse sees new bit", {31'd0, irq_pulse}, 1);
        step(1'b1, STAT, 32'h2, 1'b0, 1'b1);
        chk("R8 pulse when set meets clear", {31'd0, irq_pulse}, 1);
        rd(STAT, d); chk("R8 bit kept", d, 32'h2);
        step(1'b1, MASK, 32'h1, 1'b0, 1'b0);
        chk("R7 no pulse, mask hides bit", {31'd0, irq_pulse}, 0);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_events();
                t_clear();
                t_mask_decode();
                t_line();
                t_msi();
                t_coincide();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule